// File: doc/BRIEF.md
# Banked Byte Memory with Pointer Indirection

This block is the data store of a small 8-bit controller core. The core sees one byte-wide access port with an 8-bit address. Each access reaches one of two regions. The lower addresses hold control registers, and every bank sees the same ones. The upper addresses hold scratch RAM, split into banks. A 2-bit bank selector register picks the bank. The RAM in bank 0 starts lower than the RAM in the other banks. The number of banks that have storage is a build parameter.

Two address slots hold no data. An access to either one goes to the address held in its companion pointer register. The first slot always reaches bank 0. The second slot reaches whichever bank the selector currently names. A pointer that names either of these slots leads to a dead access. Reads are combinational and return data in the cycle the strobe is high. Writes take effect on the rising clock edge.

The port is a plain strobe interface with no back-pressure. Every strobe is accepted in its own cycle, so no valid/ready pair is needed. A read and a write may be raised in the same cycle. The read then returns the value from before the write.

Top module: `bram_top`

## Requirements
- R1: A synchronous active-high `rst` clears pointer 0 (01H), pointer 1 (03H), the bank selector (04H) and the bank-1-only register (40H) to 00H. RAM contents are not cleared.
- R2: `rdata` is 00H in every cycle where `rd` is low. While `rd` is high, `rdata` gives the addressed value in the same cycle. A write is visible from the cycle after the rising edge that stores it.
- R3: Scratch RAM covers 60H–FFH in bank 0 and 80H–FFH in banks 1–3. Bits [1:0] of the bank selector pick the bank, and each bank keeps its own contents.
- R4: A bank at or above parameter `NUM_BANKS` reads 00H in its RAM range and ignores writes there.
- R5: Registers at 01H, 03H and 04H answer at the same address in every bank. They can also be reached through a pointer.
- R6: Register 40H answers only when the resolved bank is 1. In any other bank, 40H reads 00H and a write there leaves the register unchanged.
- R7: An access at 00H goes to the address held in pointer 0, always in bank 0, whatever the bank selector holds.
- R8: An access at 02H goes to the address held in pointer 1, in the bank the selector currently names.
- R9: If the pointer used by an access at 00H or 02H holds 00H or 02H, the read returns 00H and the write changes nothing.
- R10: A write to 04H stores only bits [1:0]. A read of 04H returns those two bits with bits [7:2] as zero. The new bank applies from the next cycle on.
- R11: Control-area addresses with no register (any address below the bank's RAM range other than 01H, 03H, 04H and 40H) read 00H and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the control registers |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, 00H when `rd` is low |

## Verification
The hardest case to reach from the ports is a dead pointer loop: a pointer that names one of the two indirect slots, used while the bank selector points at a bank that is different or has no storage. A second hard case is register 40H reached through pointer 0, where bank 0 is forced, compared with the same register reached through pointer 1 while bank 1 is selected. The bench first loads every RAM location in every bank, including the bank that has no storage. Directed sequences then set the pointers and the selector to each of these combinations. A long random phase follows. It favours the pointer, selector and indirect addresses, so that loops and bank changes in the middle of a sequence come up again and again. A behavioural model checks `rdata` on every clock.

// File: rtl/bram_pkg.sv
`timescale 1ns/1ps
package bram_pkg;
  localparam int MAX_BANKS = 4;
  typedef logic [1:0] bank_t;
  localparam logic [7:0] A_IND0 = 8'h00;
  localparam logic [7:0] A_PTR0 = 8'h01;
  localparam logic [7:0] A_IND1 = 8'h02;
  localparam logic [7:0] A_PTR1 = 8'h03;
  localparam logic [7:0] A_BSEL = 8'h04;
  localparam logic [7:0] A_XREG = 8'h40;
  localparam bank_t      XREG_BANK = 2'd1;
endpackage

// File: rtl/bram_route.sv
`timescale 1ns/1ps
module bram_route
  import bram_pkg::*;
(
  input  logic [7:0] addr,
  input  logic [7:0] mp0,
  input  logic [7:0] mp1,
  input  bank_t      bsel,
  output logic [7:0] tgt_addr,
  output bank_t      tgt_bank,
  output logic       blocked
);
  logic via_ptr;

  always_comb begin
    tgt_addr = addr;
    tgt_bank = bsel;
    via_ptr  = 1'b0;
    if (addr == A_IND0) begin
      tgt_addr = mp0;
      tgt_bank = '0;
      via_ptr  = 1'b1;
    end else if (addr == A_IND1) begin
      tgt_addr = mp1;
      via_ptr  = 1'b1;
    end
    blocked = via_ptr && (tgt_addr == A_IND0 || tgt_addr == A_IND1);
  end
endmodule

// File: rtl/bram_regs.sv
`timescale 1ns/1ps
module bram_regs
  import bram_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] sel_addr,
  input  bank_t      sel_bank,
  input  logic [7:0] wdata,
  output logic [7:0] mp0,
  output logic [7:0] mp1,
  output bank_t      bsel,
  output logic [7:0] rdata
);
  logic [7:0] xreg;
  logic       xreg_live;

  assign xreg_live = (sel_bank == XREG_BANK);

  always_ff @(posedge clk) begin
    if (rst) begin
      mp0  <= '0;
      mp1  <= '0;
      bsel <= '0;
      xreg <= '0;
    end else if (we) begin
      case (sel_addr)
        A_PTR0: mp0  <= wdata;
        A_PTR1: mp1  <= wdata;
        A_BSEL: bsel <= wdata[1:0];
        A_XREG: if (xreg_live) xreg <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel_addr)
      A_PTR0:  rdata = mp0;
      A_PTR1:  rdata = mp1;
      A_BSEL:  rdata = {6'b0, bsel};
      A_XREG:  rdata = xreg_live ? xreg : 8'h00;
      default: rdata = 8'h00;
    endcase
  end

  p_bsel_write_r10: assert property (@(posedge clk) disable iff (rst)
    (we && sel_addr == A_BSEL) |=> (bsel == $past(wdata[1:0])));

  p_xreg_other_bank_r6: assert property (@(posedge clk) disable iff (rst)
    (we && sel_addr == A_XREG && sel_bank != XREG_BANK) |=> $stable(xreg));

  p_ptr0_write_r7: assert property (@(posedge clk) disable iff (rst)
    (we && sel_addr == A_PTR0) |=> (mp0 == $past(wdata)));
endmodule

// File: rtl/bram_bank.sv
`timescale 1ns/1ps
module bram_bank #(
  parameter int         DEPTH = 128,
  parameter logic [7:0] BASE  = 8'h80
) (
  input  logic       clk,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int IW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [IW-1:0] idx;

  assign idx   = IW'(addr - BASE);
  assign rdata = mem[idx];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end
endmodule

// File: rtl/bram_top.sv
`timescale 1ns/1ps
module bram_top
  import bram_pkg::*;
#(
  parameter int         NUM_BANKS = 4,
  parameter logic [7:0] B0_BASE   = 8'h60,
  parameter logic [7:0] HI_BASE   = 8'h80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  logic [7:0] mp0, mp1, tgt_addr, sfr_rd, lo;
  bank_t      bsel, tgt_bank;
  logic       blocked, is_ram, ram_we, sfr_we;
  logic [7:0] bank_rd [MAX_BANKS];

  bram_route i_route (
    .addr(addr), .mp0(mp0), .mp1(mp1), .bsel(bsel),
    .tgt_addr(tgt_addr), .tgt_bank(tgt_bank), .blocked(blocked)
  );

  assign lo     = (tgt_bank == '0) ? B0_BASE : HI_BASE;
  assign is_ram = (tgt_addr >= lo);
  assign ram_we = wr && !blocked && is_ram;
  assign sfr_we = wr && !blocked && !is_ram;

  bram_regs i_regs (
    .clk(clk), .rst(rst), .we(sfr_we), .sel_addr(tgt_addr), .sel_bank(tgt_bank),
    .wdata(wdata), .mp0(mp0), .mp1(mp1), .bsel(bsel), .rdata(sfr_rd)
  );

  for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
    if (b < NUM_BANKS) begin : g_on
      localparam logic [7:0] LO = (b == 0) ? B0_BASE : HI_BASE;
      logic we_b;
      assign we_b = ram_we && (tgt_bank == 2'(b));
      bram_bank #(.DEPTH(256 - int'(LO)), .BASE(LO)) i_bank (
        .clk(clk), .we(we_b), .addr(tgt_addr), .wdata(wdata), .rdata(bank_rd[b])
      );
    end else begin : g_off
      assign bank_rd[b] = 8'h00;
    end
  end

  always_comb begin
    if (!rd || blocked) rdata = 8'h00;
    else if (is_ram)    rdata = bank_rd[tgt_bank];
    else                rdata = sfr_rd;
  end

  p_loop_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd && blocked) |-> (rdata == 8'h00));

  p_unpop_read_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd && !blocked && is_ram && int'(tgt_bank) >= NUM_BANKS) |-> (rdata == 8'h00));

  p_xreg_hidden_r6: assert property (@(posedge clk) disable iff (rst)
    (rd && tgt_addr == A_XREG && tgt_bank != XREG_BANK) |-> (rdata == 8'h00));

  p_ind0_bank0_r7: assert property (@(posedge clk) disable iff (rst)
    (addr == A_IND0) |-> (tgt_bank == '0 && tgt_addr == mp0));
endmodule

// File: tb/test_bram_top.sv
`timescale 1ns/1ps
module test_bram_top;
  localparam int NB = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;

  int checks = 0;
  int fails  = 0;
  bit live   = 0;
  bit done   = 0;

  logic [7:0] m_ram [4][256];
  logic [7:0] m_mp0, m_mp1, m_x40;
  logic [1:0] m_bp;

  bram_top #(.NUM_BANKS(NB)) i_bram_top (
    .clk(clk), .rst(rst), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #2 clk = ~clk;

  function automatic void resolve(input logic [7:0] a, output logic [7:0] ea,
                                  output int bk, output int via);
    ea = a; bk = int'(m_bp); via = 0;
    if (a == 8'h00) begin ea = m_mp0; bk = 0; via = 1; end
    else if (a == 8'h02) begin ea = m_mp1; via = 2; end
  endfunction

  function automatic int low_of(input int bk);
    return (bk == 0) ? 'h60 : 'h80;
  endfunction

  function automatic logic [7:0] model_read(input logic r, input logic [7:0] a);
    logic [7:0] ea; int bk, via;
    if (!r) return 8'h00;
    resolve(a, ea, bk, via);
    if (via != 0 && (ea == 8'h00 || ea == 8'h02)) return 8'h00;
    if (int'(ea) >= low_of(bk)) return (bk < NB) ? m_ram[bk][ea] : 8'h00;
    case (ea)
      8'h01: return m_mp0;
      8'h03: return m_mp1;
      8'h04: return {6'b0, m_bp};
      8'h40: return (bk == 1) ? m_x40 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string model_tag(input logic r, input logic [7:0] a);
    logic [7:0] ea; int bk, via;
    if (!r) return "R2";
    resolve(a, ea, bk, via);
    if (via != 0 && (ea == 8'h00 || ea == 8'h02)) return "R9";
    if (via == 1) return "R7";
    if (via == 2) return "R8";
    if (int'(ea) >= low_of(bk)) return (bk < NB) ? "R3" : "R4";
    if (ea == 8'h40) return "R6";
    if (ea == 8'h04) return "R10";
    if (ea == 8'h01 || ea == 8'h03) return "R5";
    return "R11";
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] ea; int bk, via;
    resolve(a, ea, bk, via);
    if (via != 0 && (ea == 8'h00 || ea == 8'h02)) return;
    if (int'(ea) >= low_of(bk)) begin
      if (bk < NB) m_ram[bk][ea] = d;
    end else begin
      case (ea)
        8'h01: m_mp0 = d;
        8'h03: m_mp1 = d;
        8'h04: m_bp  = d[1:0];
        8'h40: if (bk == 1) m_x40 = d;
        default: ;
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_mp0 = 8'h00; m_mp1 = 8'h00; m_bp = 2'd0; m_x40 = 8'h00;
    end else if (wr) begin
      model_write(addr, wdata);
    end
  end

  always @(negedge clk) begin
    if (live && !rst && !done) begin
      logic [7:0] exp_v;
      exp_v = model_read(rd, addr);
      checks++;
      if (rdata !== exp_v) begin
        fails++;
        $display("FAIL %s addr=%02h rd=%0b: actual=%02h expected=%02h",
                 model_tag(rd, addr), addr, rd, rdata, exp_v);
      end
    end
  end

  task automatic op(input logic r, input logic w, input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    rd = r; wr = w; addr = a; wdata = d;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [7:0] exp_v);
    op(1'b1, 1'b0, a, 8'h00);
    @(negedge clk); #0.5;
    checks++;
    if (rdata !== exp_v) begin
      fails++;
      $display("FAIL %s addr=%02h: actual=%02h expected=%02h", tag, a, rdata, exp_v);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    live = 1;
    // R1: reset values of the control registers
    rchk("R1", 8'h01, 8'h00);
    rchk("R1", 8'h03, 8'h00);
    rchk("R1", 8'h04, 8'h00);
    op(1'b0, 1'b1, 8'h04, 8'h01);
    rchk("R1", 8'h40, 8'h00);
    // R6: 40H only in bank 1
    op(1'b0, 1'b1, 8'h40, 8'hA5);
    rchk("R6", 8'h40, 8'hA5);
    op(1'b0, 1'b1, 8'h04, 8'h02);
    op(1'b0, 1'b1, 8'h40, 8'h3C);
    rchk("R6", 8'h40, 8'h00);
    op(1'b0, 1'b1, 8'h04, 8'h01);
    rchk("R6", 8'h40, 8'hA5);
    // R10: upper selector bits dropped
    op(1'b0, 1'b1, 8'h04, 8'hFE);
    rchk("R10", 8'h04, 8'h02);
    // R11: unassigned control location
    op(1'b0, 1'b1, 8'h10, 8'h77);
    rchk("R11", 8'h10, 8'h00);
    // fill every RAM location of every bank (R3, R4)
    for (int b = 0; b < 4; b++) begin
      op(1'b0, 1'b1, 8'h04, 8'(b));
      for (int a = low_of(b); a < 256; a++)
        op(1'b0, 1'b1, 8'(a), 8'(a) ^ 8'(b * 37 + 5));
    end
    // R4: unpopulated bank reads zero
    op(1'b0, 1'b1, 8'h04, 8'h03);
    rchk("R4", 8'h90, 8'h00);
    // R3: banks keep separate contents
    op(1'b0, 1'b1, 8'h04, 8'h01);
    rchk("R3", 8'h90, 8'h90 ^ 8'(42));
    op(1'b0, 1'b1, 8'h04, 8'h02);
    rchk("R3", 8'h90, 8'h90 ^ 8'(79));
    // R7: pointer 0 forced to bank 0
    op(1'b0, 1'b1, 8'h01, 8'h70);
    rchk("R7", 8'h00, 8'h70 ^ 8'(5));
    op(1'b0, 1'b1, 8'h00, 8'h5A);
    op(1'b0, 1'b1, 8'h04, 8'h00);
    rchk("R7", 8'h70, 8'h5A);
    // R8: pointer 1 follows the selector
    op(1'b0, 1'b1, 8'h03, 8'hC0);
    op(1'b0, 1'b1, 8'h04, 8'h02);
    rchk("R8", 8'h02, 8'hC0 ^ 8'(79));
    op(1'b0, 1'b1, 8'h04, 8'h01);
    rchk("R8", 8'h02, 8'hC0 ^ 8'(42));
    // R5: 40H via pointer 1 in bank 1, hidden via pointer 0
    op(1'b0, 1'b1, 8'h03, 8'h40);
    rchk("R5", 8'h02, 8'hA5);
    op(1'b0, 1'b1, 8'h01, 8'h40);
    rchk("R6", 8'h00, 8'h00);
    op(1'b0, 1'b1, 8'h01, 8'h04);
    rchk("R5", 8'h00, 8'h01);
    // R9: pointer loops
    op(1'b0, 1'b1, 8'h01, 8'h02);
    op(1'b1, 1'b1, 8'h00, 8'hEE);
    rchk("R9", 8'h00, 8'h00);
    op(1'b0, 1'b1, 8'h03, 8'h00);
    op(1'b0, 1'b1, 8'h02, 8'hEE);
    rchk("R9", 8'h02, 8'h00);
    rchk("R9", 8'h01, 8'h02);
    // R2: no read strobe
    op(1'b0, 1'b0, 8'h01, 8'h00);
    op(1'b0, 1'b0, 8'h90, 8'h00);
    // random phase, compared every clock by the model
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] a;
      int pick;
      pick = int'($urandom % 10);
      if (pick < 4) a = 8'($urandom % 5);
      else if (pick == 4) a = 8'h40;
      else if (pick == 5) a = 8'($urandom % 8'h60);
      else a = 8'($urandom);
      op(1'($urandom % 4 != 0), 1'($urandom % 3 == 0), a,
         (a == 8'h01 || a == 8'h03) && ($urandom % 4 == 0) ? 8'($urandom % 3) : 8'($urandom));
    end
    op(1'b0, 1'b0, 8'h00, 8'h00);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule